// File: doc/BRIEF.md
# NAND bus access timing generator

This block turns one host request into a single strobed transfer on an 8-bit NAND-style bus. An accepted request is sequenced through setup, strobe-low, hold and a one-cycle completion phase. Every phase length comes from a programmed count. Each request chooses one of two timing sets, common or attribute. Command and address cycles can then run with slower timing than data cycles, even though the protocol treats every cycle as an ordinary write.

The command-latch and address-latch outputs follow two request address bits. Software sends a command or an address byte by writing to the matching address window. On writes, the data bus is driven for a programmable number of cycles from the start of the access. On reads, the bus is sampled as the read strobe rises and the byte is returned with a done pulse. An optional ready input can stretch the strobe-low phase while the device is busy.

Top module: `nand_strobe_seq`

## Requirements
- R1: After a request is accepted, chip enable (active low) is low and both strobes are high for exactly SET+1 cycles, where SET is the selected setup count.
- R2: With wait extension disabled, exactly one strobe is low for WAIT+1 cycles, where WAIT is the selected strobe count. The ready input is then ignored even when it is low.
- R3: After the strobe rises, chip enable stays low with both strobes high for HOLD cycles on a write and HOLD+2 cycles on a read. Then follows one cycle with done high and chip enable high, after which the block is idle.
- R4: A write pulses only the write strobe, and the read strobe stays high for the whole access. A read pulses only the read strobe, and the write strobe stays high.
- R5: Bit 0 of the request address-high field (address bit 16) drives the command-latch output. Bit 1 (address bit 17) drives the address-latch output. Both hold their values through setup, strobe and hold, and are low at all other times.
- R6: A request with the attribute flag set uses the attribute timing set. Otherwise the common set is used. The set is latched when the request is accepted.
- R7: On a write, the data output enable is high for the first HIZ+1 cycles of the access, cut short if the access ends first. The data output then carries the request byte. On reads and while idle the enable is low.
- R8: With wait extension enabled, the strobe stays low past WAIT+1 cycles until a clock edge sees the ready input high.
- R9: On a read, the read-data output holds the value of the data input at the clock edge where the read strobe rises. It is valid when done is high, and later input changes do not disturb it.
- R10: A request is accepted only while idle. Busy is high from the cycle after acceptance through the done cycle, and a request that arrives while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_attr | input | 1 | 1 = attribute timing set, 0 = common set |
| req_addr_hi | input | 2 | Request address bits 17:16 (bit 0 drives CLE, bit 1 drives ALE) |
| req_wdata | input | 8 | Write byte |
| com_setup | input | 8 | Common set: setup count |
| com_strobe | input | 8 | Common set: strobe-low count |
| com_hold | input | 8 | Common set: hold count |
| com_hiz | input | 8 | Common set: write drive count |
| att_setup | input | 8 | Attribute set: setup count |
| att_strobe | input | 8 | Attribute set: strobe-low count |
| att_hold | input | 8 | Attribute set: hold count |
| att_hiz | input | 8 | Attribute set: write drive count |
| wait_en | input | 1 | Enables strobe stretching by the ready input |
| bus_ready | input | 1 | Device ready, low = busy |
| dq_in | input | 8 | Data bus input |
| nce | output | 1 | Chip enable, active low |
| nwe | output | 1 | Write strobe, active low |
| noe | output | 1 | Read strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| rdata | output | 8 | Captured read byte |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Some properties are checked on every cycle:
- The two strobes are never low together.
- A strobe is never low while chip enable is high.
- Done is a single-cycle pulse with chip enable high.
- The idle bus is quiet.
- The latch-enable outputs are stable during an access.
- The output enable never overlaps a read strobe.
- A stalled strobe phase stays low while ready is low.
- Acceptance happens only while idle.

Only the bench scenarios can show the exact phase lengths for each count, and the choice between the two timing sets. The same holds for the two hold rules for reads and writes, the drive window cut short at the end of the access, the read sampling instant, and requests dropped while busy.

// File: rtl/nstb_pkg.sv
package nstb_pkg;
  localparam int TW = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_WAIT,
    PH_HOLD,
    PH_DONE
  } phase_e;

  // Number of hold cycles: reads carry two extra cycles.
  function automatic logic [TW+1:0] hold_cycles(input logic [TW-1:0] h, input logic is_wr);
    logic [TW+1:0] base;
    base = {2'b00, h};
    return is_wr ? base : base + 2;
  endfunction

  // Number of cycles the write data is driven from access start.
  function automatic logic [TW:0] drive_cycles(input logic [TW-1:0] hiz);
    return {1'b0, hiz} + 1'b1;
  endfunction
endpackage

// File: rtl/nstb_timing_sel.sv
module nstb_timing_sel
  import nstb_pkg::*;
(
  input  logic          sel_attr,
  input  logic [TW-1:0] com_setup,
  input  logic [TW-1:0] com_strobe,
  input  logic [TW-1:0] com_hold,
  input  logic [TW-1:0] com_hiz,
  input  logic [TW-1:0] att_setup,
  input  logic [TW-1:0] att_strobe,
  input  logic [TW-1:0] att_hold,
  input  logic [TW-1:0] att_hiz,
  output logic [TW-1:0] t_setup,
  output logic [TW-1:0] t_strobe,
  output logic [TW-1:0] t_hold,
  output logic [TW-1:0] t_hiz
);
  always_comb begin
    if (sel_attr) begin
      t_setup  = att_setup;
      t_strobe = att_strobe;
      t_hold   = att_hold;
      t_hiz    = att_hiz;
    end else begin
      t_setup  = com_setup;
      t_strobe = com_strobe;
      t_hold   = com_hold;
      t_hiz    = com_hiz;
    end
  end
endmodule

// File: rtl/nstb_phase_fsm.sv
module nstb_phase_fsm
  import nstb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_wr,
  input  logic [TW-1:0] t_setup,
  input  logic [TW-1:0] t_strobe,
  input  logic [TW-1:0] t_hold,
  input  logic          wait_en,
  input  logic          bus_ready,
  output phase_e        phase,
  output logic          wr_q,
  output logic          strobe_last,
  output logic          rise_evt
);
  phase_e        ph;
  logic [TW+1:0] cnt;
  logic [TW-1:0] strobe_q;
  logic [TW-1:0] hold_q;
  logic [TW+1:0] hold_n;
  logic          stall;

  assign hold_n      = hold_cycles(hold_q, wr_q);
  assign strobe_last = (ph == PH_WAIT) && (cnt == '0);
  assign stall       = wait_en && !bus_ready;
  assign rise_evt    = strobe_last && !stall;
  assign phase       = ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
      wr_q     <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph       <= PH_SETUP;
            cnt      <= {2'b00, t_setup};
            strobe_q <= t_strobe;
            hold_q   <= t_hold;
            wr_q     <= is_wr;
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            ph  <= PH_WAIT;
            cnt <= {2'b00, strobe_q};
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (!stall) begin
            if (hold_n == '0) begin
              ph <= PH_DONE;
            end else begin
              ph  <= PH_HOLD;
              cnt <= hold_n - 1'b1;
            end
          end
        end
        PH_HOLD: begin
          if (cnt == '0) ph <= PH_DONE;
          else cnt <= cnt - 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nstb_pin_drv.sv
module nstb_pin_drv
  import nstb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  phase_e        phase,
  input  logic          wr_q,
  input  logic          rise_evt,
  input  logic [1:0]    addr_hi,
  input  logic [DW-1:0] wdata,
  input  logic [TW-1:0] t_hiz,
  input  logic [DW-1:0] dq_in,
  output logic          nce,
  output logic          nwe,
  output logic          noe,
  output logic          cle,
  output logic          ale,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rdata
);
  logic          in_access;
  logic          strobe_on;
  logic [1:0]    addr_q;
  logic [DW-1:0] wdata_q;
  logic [TW:0]   drive_rem;

  assign in_access = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);
  assign strobe_on = (phase == PH_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wdata_q   <= '0;
      drive_rem <= '0;
      rdata     <= '0;
    end else begin
      if (start) begin
        addr_q    <= addr_hi;
        wdata_q   <= wdata;
        drive_rem <= drive_cycles(t_hiz);
      end else if (in_access && drive_rem != '0) begin
        drive_rem <= drive_rem - 1'b1;
      end
      if (rise_evt && !wr_q) rdata <= dq_in;
    end
  end

  assign nce    = !in_access;
  assign nwe    = !(strobe_on && wr_q);
  assign noe    = !(strobe_on && !wr_q);
  assign cle    = in_access && addr_q[0];
  assign ale    = in_access && addr_q[1];
  assign dq_out = wdata_q;
  assign dq_oe  = in_access && wr_q && (drive_rem != '0);
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nstb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_attr,
  input  logic [1:0]    req_addr_hi,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] com_setup,
  input  logic [TW-1:0] com_strobe,
  input  logic [TW-1:0] com_hold,
  input  logic [TW-1:0] com_hiz,
  input  logic [TW-1:0] att_setup,
  input  logic [TW-1:0] att_strobe,
  input  logic [TW-1:0] att_hold,
  input  logic [TW-1:0] att_hiz,
  input  logic          wait_en,
  input  logic          bus_ready,
  input  logic [DW-1:0] dq_in,
  output logic          nce,
  output logic          nwe,
  output logic          noe,
  output logic          cle,
  output logic          ale,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rdata,
  output logic          busy,
  output logic          done
);
  phase_e        phase;
  logic          wr_q;
  logic          strobe_last;
  logic          rise_evt;
  logic          accept_evt;
  logic [TW-1:0] t_setup, t_strobe, t_hold, t_hiz;

  assign accept_evt = req_valid && (phase == PH_IDLE);
  assign busy       = (phase != PH_IDLE);
  assign done       = (phase == PH_DONE);

  nstb_timing_sel u_sel (
    .sel_attr   (req_attr),
    .com_setup  (com_setup),
    .com_strobe (com_strobe),
    .com_hold   (com_hold),
    .com_hiz    (com_hiz),
    .att_setup  (att_setup),
    .att_strobe (att_strobe),
    .att_hold   (att_hold),
    .att_hiz    (att_hiz),
    .t_setup    (t_setup),
    .t_strobe   (t_strobe),
    .t_hold     (t_hold),
    .t_hiz      (t_hiz)
  );

  nstb_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept_evt),
    .is_wr       (req_write),
    .t_setup     (t_setup),
    .t_strobe    (t_strobe),
    .t_hold      (t_hold),
    .wait_en     (wait_en),
    .bus_ready   (bus_ready),
    .phase       (phase),
    .wr_q        (wr_q),
    .strobe_last (strobe_last),
    .rise_evt    (rise_evt)
  );

  nstb_pin_drv #(.DW(DW)) u_pins (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept_evt),
    .phase    (phase),
    .wr_q     (wr_q),
    .rise_evt (rise_evt),
    .addr_hi  (req_addr_hi),
    .wdata    (req_wdata),
    .t_hiz    (t_hiz),
    .dq_in    (dq_in),
    .nce      (nce),
    .nwe      (nwe),
    .noe      (noe),
    .cle      (cle),
    .ale      (ale),
    .dq_out   (dq_out),
    .dq_oe    (dq_oe),
    .rdata    (rdata)
  );
endmodule

// File: rtl/nstb_chk.sv
module nstb_chk (
  input logic clk,
  input logic rst_n,
  input logic nce,
  input logic nwe,
  input logic noe,
  input logic cle,
  input logic ale,
  input logic dq_oe,
  input logic busy,
  input logic done,
  input logic wait_en,
  input logic bus_ready,
  input logic accept_evt,
  input logic strobe_last
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(!nwe && !noe)); // R4
  AST_STROBE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_n) (!nwe || !noe) |-> !nce); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R3
  AST_DONE_CE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) done |-> (nce && busy)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (nce && !dq_oe && !cle && !ale)); // R10
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (!nce && $past(!nce)) |-> ($stable(cle) && $stable(ale))); // R5
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n) !noe |-> !dq_oe); // R7
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (strobe_last && wait_en && !bus_ready) |=> (!nwe || !noe)); // R8
  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) accept_evt |-> !busy); // R10
endmodule

bind nand_strobe_seq nstb_chk i_nstb_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .nce         (nce),
  .nwe         (nwe),
  .noe         (noe),
  .cle         (cle),
  .ale         (ale),
  .dq_oe       (dq_oe),
  .busy        (busy),
  .done        (done),
  .wait_en     (wait_en),
  .bus_ready   (bus_ready),
  .accept_evt  (accept_evt),
  .strobe_last (strobe_last)
);

// File: tb/test_nand_strobe_seq.sv
`timescale 1ns/1ps
module test_nand_strobe_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0, req_write = 1'b0, req_attr = 1'b0;
  logic [1:0] req_addr_hi = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] com_setup = '0, com_strobe = '0, com_hold = '0, com_hiz = '0;
  logic [7:0] att_setup = '0, att_strobe = '0, att_hold = '0, att_hiz = '0;
  logic       wait_en = 1'b0, bus_ready = 1'b1;
  logic [7:0] dq_in = '0;
  logic       nce, nwe, noe, cle, ale, dq_oe, busy, done;
  logic [7:0] dq_out, rdata;

  int ntests = 0;
  int nfail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  nand_strobe_seq i_nand_strobe_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_attr(req_attr), .req_addr_hi(req_addr_hi), .req_wdata(req_wdata),
    .com_setup(com_setup), .com_strobe(com_strobe), .com_hold(com_hold), .com_hiz(com_hiz),
    .att_setup(att_setup), .att_strobe(att_strobe), .att_hold(att_hold), .att_hiz(att_hiz),
    .wait_en(wait_en), .bus_ready(bus_ready), .dq_in(dq_in),
    .nce(nce), .nwe(nwe), .noe(noe), .cle(cle), .ale(ale),
    .dq_out(dq_out), .dq_oe(dq_oe), .rdata(rdata), .busy(busy), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Vector: write, attr, addr_hi[1:0], setup, strobe, hold, hiz, data
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b01, 4'd0,  4'd0,  4'd0,  4'd0, 8'h00},
    {1'b1, 1'b1, 2'b10, 4'd2,  4'd1,  4'd1,  4'd15, 8'h5A},
    {1'b0, 1'b0, 2'b00, 4'd1,  4'd3,  4'd0,  4'd5, 8'h3C},
    {1'b0, 1'b1, 2'b01, 4'd3,  4'd0,  4'd2,  4'd0, 8'hC3},
    {1'b1, 1'b0, 2'b00, 4'd4,  4'd2,  4'd3,  4'd2, 8'hA5},
    {1'b1, 1'b1, 2'b11, 4'd1,  4'd1,  4'd2,  4'd4, 8'h81},
    {1'b0, 1'b0, 2'b10, 4'd0,  4'd0,  4'd1,  4'd3, 8'h7E},
    {1'b1, 1'b0, 2'b00, 4'd15, 4'd15, 4'd15, 4'd9, 8'hFF}
  };

  // One access; measures every phase at the pins and compares with the rules.
  // rel_k > 0: raise bus_ready once rel_k strobe-low cycles were seen.
  // poke: issue a competing request during setup.
  task automatic run_access(input bit w, input bit at, input logic [1:0] ca,
                            input int st, input int wt, input int ho, input int hz,
                            input logic [7:0] dat, input int exp_strobe,
                            input int rel_k, input bit poke);
    int nsu = 0, ns = 0, nho = 0, oe_c = 0, bad = 0, cbad = 0, dbad = 0, bbad = 0, gap = 0;
    int n = 0, total, exp_oe, exp_hold;
    bit flipped = 0, seen_done = 0;
    @(negedge clk);
    if (at) begin
      att_setup = 8'(st); att_strobe = 8'(wt); att_hold = 8'(ho); att_hiz = 8'(hz);
      com_setup = 8'd6;   com_strobe = 8'd5;   com_hold = 8'd4;   com_hiz = 8'd3;
    end else begin
      com_setup = 8'(st); com_strobe = 8'(wt); com_hold = 8'(ho); com_hiz = 8'(hz);
      att_setup = 8'd6;   att_strobe = 8'd5;   att_hold = 8'd4;   att_hiz = 8'd3;
    end
    req_valid = 1'b1; req_write = w; req_attr = at; req_addr_hi = ca;
    req_wdata = dat; dq_in = dat;
    @(negedge clk);
    req_valid = 1'b0; req_addr_hi = ~ca; req_wdata = ~dat; req_attr = ~at;
    while (n < 400) begin
      n++;
      if (done) begin seen_done = 1; break; end
      if (!busy) bbad++;
      if (!nce) begin
        if (!nwe || !noe) begin
          ns++;
          if (w ? !noe : !nwe) bad++;
          if (rel_k > 0 && ns == rel_k) bus_ready = 1'b1;
        end else if (ns == 0) nsu++;
        else begin
          nho++;
          if (!flipped) begin dq_in = ~dat; flipped = 1; end
        end
        if (cle != ca[0] || ale != ca[1]) cbad++;
        if (dq_oe) begin
          oe_c++;
          if (dq_out != dat) dbad++;
        end
      end else gap++;
      if (poke && n == 1) begin
        req_valid = 1'b1; req_write = ~w; req_attr = ~at;
      end else if (poke && n == 2) req_valid = 1'b0;
      @(negedge clk);
    end
    if (!flipped) dq_in = ~dat;
    exp_hold = w ? ho : ho + 2;
    total = (st + 1) + exp_strobe + exp_hold;
    exp_oe = w ? ((hz + 1 < total) ? hz + 1 : total) : 0;
    chk("R3 done pulse reached", int'(seen_done), 1);
    chk("R1/R6 setup cycles", nsu, st + 1);
    chk("R2/R8 strobe-low cycles", ns, exp_strobe);
    chk("R3 hold cycles", nho, exp_hold);
    chk("R4 wrong strobe cycles", bad, 0);
    chk("R5 cle/ale mismatches", cbad, 0);
    chk("R7 drive cycles", oe_c, exp_oe);
    chk("R7 dq_out mismatches", dbad, 0);
    chk("R10 busy low during access", bbad + gap, 0);
    chk("R3 nce high at done", int'(nce), 1);
    if (!w) chk("R9 read data", int'(rdata), int'(dat));
    @(negedge clk);
    chk("R3 idle after done: busy", int'(busy), 0);
    chk("R3 single done pulse", int'(done), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nfail++; ntests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // Reset state, R10 and R4 at rest
    chk("R10 reset busy", int'(busy), 0);
    chk("R3 reset done", int'(done), 0);
    chk("R1 reset nce", int'(nce), 1);
    chk("R4 reset strobes", int'({nwe, noe}), 3);
    chk("R7 reset dq_oe", int'(dq_oe), 0);
    chk("R5 reset cle/ale", int'({cle, ale}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", int'(busy), 0);

    // Vector table walk (R1..R7, R9)
    for (int i = 0; i < NV; i++) begin
      logic [27:0] v;
      v = VEC[i];
      run_access(v[27], v[26], v[25:24], int'(v[23:20]), int'(v[19:16]),
                 int'(v[15:12]), int'(v[11:8]), v[7:0], int'(v[19:16]) + 1, 0, 1'b0);
    end

    // R8: stall with wait enabled; ready released after 6 strobe cycles
    wait_en = 1'b1; bus_ready = 1'b0;
    run_access(1'b0, 1'b0, 2'b00, 1, 1, 1, 0, 8'h96, 6, 6, 1'b0);
    // R8: wait enabled but ready high, strobe keeps nominal length
    bus_ready = 1'b1;
    run_access(1'b1, 1'b1, 2'b01, 0, 3, 0, 1, 8'h42, 4, 0, 1'b0);
    // R2: wait disabled, ready low ignored
    wait_en = 1'b0; bus_ready = 1'b0;
    run_access(1'b0, 1'b1, 2'b10, 2, 2, 0, 0, 8'h18, 3, 0, 1'b0);
    bus_ready = 1'b1;

    // R10: competing request during an access is dropped
    run_access(1'b1, 1'b0, 2'b11, 2, 1, 1, 1, 8'h6D, 2, 0, 1'b1);
    for (int k = 0; k < 4; k++) begin
      chk("R10 dropped request: nce", int'(nce), 1);
      chk("R10 dropped request: busy", int'(busy), 0);
      @(negedge clk);
    end

    // R9: read data held through a following write
    run_access(1'b0, 1'b0, 2'b00, 0, 0, 0, 0, 8'hE7, 1, 0, 1'b0);
    run_access(1'b1, 1'b0, 2'b00, 0, 0, 0, 0, 8'h11, 1, 0, 1'b0);
    chk("R9 rdata kept after write", int'(rdata), 8'hE7);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule